// File: doc/BRIEF.md
# Masked Two-Wire Slave Address Detector

This block listens on a two-wire serial bus (I2C) and decides whether the address byte that follows a START condition is meant for this slave. It passes both bus lines through synchronizers into the system clock domain. It shifts in the address byte on rising clock-line edges, most significant bit first. It then compares the seven address bits against a programmed own address. A per-bit mask can exclude any address bit from that compare. An optional enable adds recognition of the all-zero general-call address.

On a match the block sets a sticky flag and records the kind of match and the direction bit. The flag is also offered as an interrupt request, gated by a local enable. Software programs and observes the block through a small four-entry register interface, with combinational reads and single-cycle writes. Once the byte has been judged, the detector ignores the bus until the next START or STOP, so data bytes never cause a compare. While the flag is pending, new START conditions are ignored.

Top module: `i2c_addr_match`

## Requirements
- R1: After synchronous reset, every register reads as zero and `irq` is low.
- R2: Register select 0 holds the own address in bits 7..1 and the general-call enable in bit 0, and reads back exactly what was written.
- R3: Register select 1 holds the address mask in bits 7..1. Its bit 0 always reads as zero, and writing a one there has no effect on readback or on matching.
- R4: A START is SDA falling while SCL is high. The next eight bits sampled on rising SCL are the address (MSB first) followed by the R/W bit. When the address equals the own address, the flag (select 2, bit 7) is set and the status register (select 3) reads bit 0 = own match, bit 1 = general-call match, bit 2 = R/W.
- R5: An address bit whose mask bit is one is excluded from the compare and treated as equal.
- R6: With general-call enable set, address 0x00 with R/W = 0 sets the flag with status bit 1 and clear bit 0, whatever the own address and mask hold.
- R7: With general-call enable set, address 0x00 with R/W = 1 is not a match. With the enable clear, address 0x00 goes through the ordinary masked compare.
- R8: The flag stays set until a write to select 2 with bit 7 = 1. A write with bit 7 = 0 leaves it set. Status is only reloaded by a new match.
- R9: `irq` equals the flag ANDed with the interrupt enable (select 2, bit 0).
- R10: While the flag is set, STARTs are ignored. After a byte has been judged, or after a STOP, bits clocked without a new START cause no compare.
- R11: A repeated START in the middle of an address byte discards the partial byte and restarts capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line, asynchronous |
| sda_in | input | 1 | Serial data line, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_sel` |
| irq | output | 1 | Interrupt request |

## Verification
The in-line assertions check the following on every cycle:
- the flag cannot drop without a clear write;
- the interrupt never rises without its enable;
- own and general-call status are never set together;
- a general-call status always carries R/W = 0;
- no capture is in progress while the flag is pending.

Only the bench's scenarios can show the rest:
- that the masked compare, the general-call rule and the bit order are right across all 128 addresses in several configurations;
- that STOP, repeated START and data bytes with no START behave as stated.

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
  parameter int ADDR_BITS   = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_in,
  input  logic                 sda_in,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_sel,
  input  logic [ADDR_BITS:0]   reg_wdata,
  output logic [ADDR_BITS:0]   reg_rdata,
  output logic                 irq
);
  localparam int REG_W = ADDR_BITS + 1;
  localparam int CNT_W = $clog2(REG_W + 1);

  logic [SYNC_STAGES-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  wire  scl_s = scl_sy[SYNC_STAGES-1];
  wire  sda_s = sda_sy[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sy <= '0; sda_sy <= '0; scl_d <= 1'b0; sda_d <= 1'b0;
    end else begin
      scl_sy <= {scl_sy[SYNC_STAGES-2:0], scl_in};
      sda_sy <= {sda_sy[SYNC_STAGES-2:0], sda_in};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  wire bus_start = scl_s & scl_d &  sda_d & ~sda_s;
  wire bus_stop  = scl_s & scl_d & ~sda_d &  sda_s;
  wire scl_rise  = scl_s & ~scl_d;

  logic [ADDR_BITS-1:0] own_q, mask_q;
  logic gce_q, ie_q, flag_q;
  logic st_own, st_gc, st_rw;
  logic capt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [REG_W-2:0] sh_q;

  wire [REG_W-1:0]     word   = {sh_q, sda_s};
  wire [ADDR_BITS-1:0] rx_adr = word[REG_W-1:1];
  wire                 rx_rw  = word[0];
  wire last_bit  = capt_q & scl_rise & (cnt_q == CNT_W'(REG_W-1));
  wire is_zero   = (rx_adr == '0);
  wire gc_case   = is_zero & gce_q;
  wire gc_hit    = gc_case & ~rx_rw;
  wire own_hit   = (((rx_adr ^ own_q) & ~mask_q) == '0) & ~gc_case;
  wire any_hit   = gc_hit | own_hit;
  wire clr_wr    = reg_wr & (reg_sel == 2'd2) & reg_wdata[REG_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      capt_q <= 1'b0; cnt_q <= '0; sh_q <= '0;
    end else if (bus_stop) begin
      capt_q <= 1'b0;
    end else if (bus_start) begin
      capt_q <= ~flag_q;
      cnt_q  <= '0;
    end else if (capt_q && scl_rise) begin
      sh_q  <= word[REG_W-2:0];
      cnt_q <= cnt_q + 1'b1;
      if (last_bit) capt_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0; gce_q <= 1'b0; mask_q <= '0; ie_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_sel)
        2'd0: begin own_q <= reg_wdata[REG_W-1:1]; gce_q <= reg_wdata[0]; end
        2'd1: mask_q <= reg_wdata[REG_W-1:1];
        2'd2: ie_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0; st_own <= 1'b0; st_gc <= 1'b0; st_rw <= 1'b0;
    end else if (last_bit && any_hit) begin
      flag_q <= 1'b1;
      st_own <= own_hit;
      st_gc  <= gc_hit;
      st_rw  <= rx_rw;
    end else if (clr_wr) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_sel)
      2'd0:    reg_rdata = {own_q, gce_q};
      2'd1:    reg_rdata = {mask_q, 1'b0};
      2'd2:    reg_rdata = {flag_q, {(REG_W-2){1'b0}}, ie_q};
      default: reg_rdata = {{(REG_W-3){1'b0}}, st_rw, st_gc, st_own};
    endcase
  end

  assign irq = flag_q & ie_q;

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_wr) |=> flag_q); // R8
  AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ie_q); // R9
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_own, st_gc})); // R6
  AST_GC_WRITE_DIR: assert property (@(posedge clk) disable iff (rst)
    st_gc |-> !st_rw); // R7
  AST_NO_CAPT_PENDING: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> !capt_q); // R10
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> (st_own || st_gc)); // R4
endmodule

// File: tb/sim_i2c_addr_match.sv
module sim_i2c_addr_match;
  logic clk = 1'b0, rst = 1'b1, scl = 1'b1, sda = 1'b1;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq;
  int n_tot = 0, n_ok = 0;
  bit done = 0;
  logic [6:0] m_own, m_mask;
  logic m_gce;
  logic [2:0] m_st;

  always #10 clk = ~clk;

  i2c_addr_match u0 (.clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tot++;
    if (ok) n_ok++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic ph(); repeat (4) @(posedge clk); endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic bstart(); sda = 1; ph(); scl = 1; ph(); sda = 0; ph(); scl = 0; ph(); endtask
  task automatic bstop();  sda = 0; ph(); scl = 1; ph(); sda = 1; ph(); endtask
  task automatic bbits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin sda = b[i]; ph(); scl = 1; ph(); scl = 0; ph(); end
  endtask

  task automatic cfg(input logic [7:0] own_r, input logic [7:0] mask_r);
    wr(2'd0, own_r); wr(2'd1, mask_r);
    m_own = own_r[7:1]; m_gce = own_r[0]; m_mask = mask_r[7:1];
  endtask

  function automatic logic [2:0] model(input logic [6:0] a, input logic rw);
    logic gcc, gh, oh;
    gcc = (a == 7'd0) && m_gce;
    gh = gcc && !rw;
    oh = (((a ^ m_own) & ~m_mask) == 7'd0) && !gcc;
    return {rw, gh, oh};
  endfunction

  task automatic txn(input logic [6:0] a, input logic rw, input string tag);
    logic [7:0] d; logic [2:0] e; logic hit;
    wr(2'd2, 8'h81);
    bstart(); bbits({a, rw}, 8); bstop();
    e = model(a, rw); hit = e[0] | e[1];
    if (hit) m_st = e;
    rd(2'd2, d); chk(d[7] == hit, {tag, " flag"}, d[7], hit);
    rd(2'd3, d); chk(d[2:0] == m_st, {tag, " status"}, d[2:0], m_st);
    chk(irq == hit, "R9 irq", irq, hit);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_tot++; $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_ok, n_tot); $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk); @(negedge clk); rst = 0;
    m_st = 3'b0;
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], d); chk(d == 8'h00, "R1 reset reg", d, 0);
    end
    chk(irq == 1'b0, "R1 reset irq", irq, 0);

    wr(2'd0, 8'hA5); rd(2'd0, d); chk(d == 8'hA5, "R2 own readback", d, 8'hA5);
    wr(2'd1, 8'hFF); rd(2'd1, d); chk(d == 8'hFE, "R3 mask bit0", d, 8'hFE);

    cfg(8'h55, 8'h00);
    for (int a = 0; a < 128; a++) for (int rw = 0; rw < 2; rw++) txn(a[6:0], rw[0], "R4");
    cfg(8'hAB, 8'h1F);
    for (int a = 0; a < 128; a++) for (int rw = 0; rw < 2; rw++) txn(a[6:0], rw[0], "R5 R3");
    cfg(8'h6D, 8'h34);
    for (int a = 0; a < 128; a++) for (int rw = 0; rw < 2; rw++) txn(a[6:0], rw[0], "R6 R7");
    cfg(8'h00, 8'h00);
    for (int a = 0; a < 4; a++) for (int rw = 0; rw < 2; rw++) txn(a[6:0], rw[0], "R7 gce off");

    cfg(8'h6D, 8'h00);
    wr(2'd2, 8'h81); bstart(); bbits({7'h36, 1'b0}, 8); bstop();
    wr(2'd2, 8'h00); rd(2'd2, d); chk(d[7] == 1'b1, "R8 write0 keeps flag", d[7], 1);
    chk(irq == 1'b0, "R9 irq gated off", irq, 0);
    wr(2'd2, 8'h01); chk(irq == 1'b1, "R9 irq on", irq, 1);
    bstart(); bbits({7'h36, 1'b1}, 8); bstop();
    rd(2'd3, d); chk(d[2:0] == 3'b001, "R10 start ignored while pending", d[2:0], 1);
    wr(2'd2, 8'h81); rd(2'd2, d); chk(d[7] == 1'b0, "R8 clear", d[7], 0);
    chk(irq == 1'b0, "R9 irq after clear", irq, 0);

    bstart(); bbits({7'h11, 1'b0}, 8); bbits({7'h36, 1'b1}, 8); bstop();
    rd(2'd2, d); chk(d[7] == 1'b0, "R10 data byte ignored", d[7], 0);
    bstart(); bbits(8'h36, 4); bstop(); bbits({7'h36, 1'b1}, 8); bbits({7'h36, 1'b1}, 8);
    rd(2'd2, d); chk(d[7] == 1'b0, "R10 stop aborts", d[7], 0);

    bstart(); bbits(8'h00, 3); bstart(); bbits({7'h36, 1'b1}, 8); bstop();
    rd(2'd2, d); chk(d[7] == 1'b1, "R11 repeated start flag", d[7], 1);
    rd(2'd3, d); chk(d[2:0] == 3'b101, "R11 repeated start status", d[2:0], 5);

    done = 1;
    $display("%0d/%0d checks passed", n_ok, n_tot);
    $finish;
  end
endmodule